// File: doc/BRIEF.md
# Bit-Field Extract/Insert Execution Unit

This 32-bit execution unit accepts one immediate-form instruction word per cycle, together with the source register value and the current value of the destination register. It decodes the word as one of two bit-field operations. **Extract** pulls a field out of the source, moves it down to bit 0 and clears everything above it. **Insert** takes the low bits of the source, places them at a chosen position inside the old destination value, and leaves all other bits of that value unchanged.

Both operations share one major opcode and are told apart by two selector bits. The 5-bit start position is stored the same way in both forms. The other 5-bit slot is read differently:

- for extract it holds the field width;
- for insert it holds the field's top bit index, so the width is slot − start + 1.

An encoding that describes an impossible field raises an illegal flag instead of a write. The result, destination index, write-enable and illegal flag are all registered one cycle after the valid strobe.

Top module: `bitfield_unit`

## Requirements
- R1: A word matches extract when (word & 0xFC00C000) == 0x64004000, and matches insert when (word & 0xFC00C000) == 0x64008000. Any other word, including one with both selector bits 15:14 set, produces neither a write nor an illegal flag.
- R2: Bits 4:0 give the start position (0..31) and bits 10:6 give the 5-bit slot. Bits 20:16 name the source register; its value arrives on `src_i`.
- R3: When a write is issued, `rd_o` equals bits 25:21 of the word that caused it.
- R4: A legal extract returns (src >> start) masked to the slot width, with every bit from position width upward equal to zero.
- R5: An extract whose slot is 0 sets `illegal_o`, keeps `wen_o` low and leaves `result_o` unchanged.
- R6: An extract with width + start > 32 is illegal in the same way. Width + start = 32 is legal.
- R7: A legal insert recovers width = slot − start + 1. It writes the low width bits of src at positions start..slot and keeps every other bit of `dst_i`.
- R8: An insert whose slot is below its start sets `illegal_o`, keeps `wen_o` low and leaves `result_o` unchanged.
- R9: An insert with slot 31 and start 0 (a 32-bit field) returns src unchanged.
- R10: While `valid_i` is low, `wen_o` and `illegal_o` are low in the next cycle, and `result_o` and `rd_o` hold their values.
- R11: Outputs appear one clock edge after the valid strobe and last one cycle. A synchronous reset clears `wen_o`, `illegal_o`, `result_o` and `rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction word is present this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | 32 | Source register value |
| dst_i | input | 32 | Prior destination register value |
| result_o | output | 32 | Registered result |
| rd_o | output | 5 | Registered destination register index |
| wen_o | output | 1 | Write-enable, one cycle per legal operation |
| illegal_o | output | 1 | Field encoding was invalid |

## Verification
The assertions assume the following about the inputs:

- `valid_i`, `instr_i`, `src_i` and `dst_i` are stable and known at each rising edge.
- `dst_i` is the destination value that belongs to the same word as `src_i`.

The bench meets these conditions by changing inputs only on falling edges. It pairs each word with its own source and destination values, and it drops `valid_i` whenever it samples the hold behaviour.

The stimulus covers several kinds of word:

- legal boundaries: sum exactly 32, single-bit fields, the full 32-bit insert;
- each class of illegal field;
- words outside the opcode, so that every property's antecedent is actually reached.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam logic [31:0] BF_MATCH_MASK = 32'hFC00C000;
    localparam logic [31:0] BF_EXT_CODE   = 32'h64004000;
    localparam logic [31:0] BF_INS_CODE   = 32'h64008000;

    typedef enum logic [1:0] {
        BF_NONE    = 2'd0,
        BF_EXTRACT = 2'd1,
        BF_INSERT  = 2'd2
    } bf_op_e;

    typedef struct packed {
        bf_op_e     op;
        logic [4:0] rd;
        logic [4:0] start;
        logic [4:0] slot;
        logic [5:0] width;
        logic       bad;
    } bf_dec_t;

endpackage

// File: rtl/bf_decode.sv
module bf_decode
    import bf_pkg::*;
(
    input  logic [31:0] word_i,
    output bf_dec_t     dec_o
);
    localparam int unsigned FIELD_MAX = 32;

    logic [5:0] sum_w;
    logic [5:0] span_w;

    always_comb begin
        dec_o       = '0;
        dec_o.rd    = word_i[25:21];
        dec_o.start = word_i[4:0];
        dec_o.slot  = word_i[10:6];
        sum_w       = {1'b0, word_i[10:6]} + {1'b0, word_i[4:0]};
        span_w      = {1'b0, word_i[10:6]} - {1'b0, word_i[4:0]} + 6'd1;

        if ((word_i & BF_MATCH_MASK) == BF_EXT_CODE) begin
            dec_o.op    = BF_EXTRACT;
            dec_o.width = {1'b0, word_i[10:6]};
            dec_o.bad   = (word_i[10:6] == 5'd0) || (sum_w > 6'(FIELD_MAX));
        end else if ((word_i & BF_MATCH_MASK) == BF_INS_CODE) begin
            dec_o.op    = BF_INSERT;
            dec_o.bad   = (word_i[10:6] < word_i[4:0]);
            dec_o.width = dec_o.bad ? 6'd0 : span_w;
        end
    end

endmodule

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WID_W = $clog2(DATA_W) + 1
) (
    input  logic [WID_W-1:0]  width_i,
    output logic [DATA_W-1:0] mask_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask_o[i] = (WID_W'(i) < width_i);
    end
endmodule

// File: rtl/bf_extract.sv
module bf_extract #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [SH_W-1:0]   start_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb res_o = (src_i >> start_i) & mask_i;
endmodule

// File: rtl/bf_insert.sv
module bf_insert #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [SH_W-1:0]   start_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] place_w;

    always_comb begin
        place_w = mask_i << start_i;
        res_o   = (dst_i & ~place_w) | ((src_i << start_i) & place_w);
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] src_i,
    input  logic [31:0] dst_i,
    output logic [31:0] result_o,
    output logic [4:0]  rd_o,
    output logic        wen_o,
    output logic        illegal_o
);
    localparam int unsigned DATA_W = 32;
    localparam int unsigned SH_W   = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [4:0]        rd;
        logic              wen;
        logic              ill;
    } out_t;

    bf_dec_t           dec_w;
    logic [DATA_W-1:0] mask_w;
    logic [DATA_W-1:0] ext_res_w;
    logic [DATA_W-1:0] ins_res_w;
    out_t              out_d, out_q;

    bf_decode u_dec (.word_i(instr_i), .dec_o(dec_w));

    bf_mask_gen #(.DATA_W(DATA_W)) u_mask (
        .width_i (dec_w.width),
        .mask_o  (mask_w)
    );

    bf_extract #(.DATA_W(DATA_W)) u_ext (
        .src_i   (src_i),
        .start_i (dec_w.start[SH_W-1:0]),
        .mask_i  (mask_w),
        .res_o   (ext_res_w)
    );

    bf_insert #(.DATA_W(DATA_W)) u_ins (
        .src_i   (src_i),
        .dst_i   (dst_i),
        .start_i (dec_w.start[SH_W-1:0]),
        .mask_i  (mask_w),
        .res_o   (ins_res_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.wen = 1'b0;
        out_d.ill = 1'b0;
        if (valid_i && dec_w.op != BF_NONE) begin
            if (dec_w.bad) begin
                out_d.ill = 1'b1;
            end else begin
                out_d.wen    = 1'b1;
                out_d.rd     = dec_w.rd;
                out_d.result = (dec_w.op == BF_EXTRACT) ? ext_res_w : ins_res_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign result_o  = out_q.result;
    assign rd_o      = out_q.rd;
    assign wen_o     = out_q.wen;
    assign illegal_o = out_q.ill;

    // R10: an idle cycle produces no write and no flag, and the data holds
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!wen_o && !illegal_o && $stable(result_o) && $stable(rd_o)));

    // R3: the written index comes from bits 25:21 of the previous word
    a_r3_rd_field: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_w.op != BF_NONE && !dec_w.bad) |=> (wen_o && rd_o == $past(instr_i[25:21])));

    // R4: nothing survives above the extracted field
    a_r4_ext_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_w.op == BF_EXTRACT && !dec_w.bad) |=> ((result_o & ~$past(mask_w)) == '0));

    // R7: destination bits outside the inserted field are untouched
    a_r7_ins_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_w.op == BF_INSERT && !dec_w.bad) |=>
            (((result_o ^ $past(dst_i)) & ~($past(mask_w) << $past(dec_w.start))) == '0));

    // R5 R6 R8: an invalid field raises the flag and blocks the write
    a_r8_bad_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dec_w.bad) |=> (illegal_o && !wen_o && $stable(result_o)));

endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] res;
        logic        wen;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    // rd = 3 in every matching word unless noted; start in bits 4:0, slot in bits 10:6
    localparam vec_t VECS [NV] = '{
        '{32'h64614204, 32'hABCD1234, 32'h0,        32'h00000023, 1'b1, 1'b0, 4'd4},  // R4 slot8 start4
        '{32'h64614410, 32'hDEADBEEF, 32'h0,        32'h0000DEAD, 1'b1, 1'b0, 4'd6},  // R6 sum exactly 32
        '{32'h646147C1, 32'hFFFFFFFF, 32'h0,        32'h7FFFFFFF, 1'b1, 1'b0, 4'd4},  // R4 slot31 start1
        '{32'h6461405F, 32'h80000000, 32'h0,        32'h00000001, 1'b1, 1'b0, 4'd4},  // R4 one bit at 31
        '{32'h64614003, 32'hFFFFFFFF, 32'h0,        32'h00000001, 1'b0, 1'b1, 4'd5},  // R5 slot 0
        '{32'h6461450D, 32'hFFFFFFFF, 32'h0,        32'h00000001, 1'b0, 1'b1, 4'd6},  // R6 20+13
        '{32'h646182C4, 32'h000000A5, 32'hFFFFFFFF, 32'hFFFFFA5F, 1'b1, 1'b0, 4'd7},  // R7 top11 start4
        '{32'h646187C0, 32'h12345678, 32'h0,        32'h12345678, 1'b1, 1'b0, 4'd9},  // R9 full width
        '{32'h646180C5, 32'h0000FFFF, 32'h0,        32'h12345678, 1'b0, 1'b1, 4'd8},  // R8 top3 start5
        '{32'h646181C7, 32'h00000001, 32'h0,        32'h00000080, 1'b1, 1'b0, 4'd7},  // R7 one bit
        '{32'h646187DC, 32'h0000000C, 32'h12345678, 32'hC2345678, 1'b1, 1'b0, 4'd7},  // R7 top nibble
        '{32'h64610404, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hC2345678, 1'b0, 1'b0, 4'd1},  // R1 no selector
        '{32'h6461C204, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hC2345678, 1'b0, 1'b0, 4'd1},  // R1 both selectors
        '{32'h67E04100, 32'h00001234, 32'h0,        32'h00000004, 1'b1, 1'b0, 4'd3}   // R3 rd=31
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] result_o;
    logic [4:0]  rd_o;
    logic        wen_o;
    logic        illegal_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .src_i(src_i), .dst_i(dst_i), .result_o(result_o), .rd_o(rd_o),
        .wen_o(wen_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        valid_i = v; instr_i = w; src_i = s; dst_i = d;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(wen_o == 1'b0 && illegal_o == 1'b0, "R11 reset flags", {30'd0, wen_o, illegal_o}, 32'd0);
        chk(result_o == 32'd0 && rd_o == 5'd0, "R11 reset data", result_o, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VECS[i].word, VECS[i].src, VECS[i].dst);
            chk(wen_o == VECS[i].wen, $sformatf("R%0d wen vec%0d", VECS[i].req, i), {31'd0, wen_o}, {31'd0, VECS[i].wen});
            chk(illegal_o == VECS[i].ill, $sformatf("R%0d illegal vec%0d", VECS[i].req, i), {31'd0, illegal_o}, {31'd0, VECS[i].ill});
            chk(result_o == VECS[i].res, $sformatf("R%0d result vec%0d", VECS[i].req, i), result_o, VECS[i].res);
            if (VECS[i].wen)  // R3 index taken from bits 25:21
                chk(rd_o == VECS[i].word[25:21], "R3 rd field", {27'd0, rd_o}, {27'd0, VECS[i].word[25:21]});
            // R11: one-cycle pulse
            @(negedge clk);
            chk(wen_o == 1'b0 && illegal_o == 1'b0, "R11 pulse ends", {30'd0, wen_o, illegal_o}, 32'd0);
        end

        // R10: a matching word without valid is ignored and outputs hold
        issue(1'b0, 32'h64614204, 32'hFFFFFFFF, 32'h0);
        chk(wen_o == 1'b0 && illegal_o == 1'b0, "R10 valid low flags", {30'd0, wen_o, illegal_o}, 32'd0);
        chk(result_o == 32'h00000004 && rd_o == 5'd31, "R10 valid low hold", result_o, 32'h00000004);

        // R2: start and slot positions, different source field
        issue(1'b1, 32'h64614148, 32'h0000F0F0, 32'h0);  // slot5 start8
        chk(result_o == 32'h00000010, "R2 field positions", result_o, 32'h00000010);

        // R11: reset wins over a valid word at the same edge
        @(negedge clk);
        valid_i = 1'b1; instr_i = 32'h64614204; src_i = 32'hFFFFFFFF; rst = 1'b1;
        @(negedge clk);
        valid_i = 1'b0; rst = 1'b0;
        chk(wen_o == 1'b0 && result_o == 32'd0, "R11 reset clears", result_o, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule